// File: doc/BRIEF.md
# CAN Bit Timing Synchronizer

This block turns the system clock into a stream of bit-timing events for a CAN receiver and transmitter. A prescaler cuts the clock into time quanta. Each bit is then run through three phases: a one-quantum sync phase, a first phase of `tseg1_i+1` quanta and a second phase of `tseg2_i+1` quanta. At the boundary between the two phases the block raises a one-cycle sample strobe and latches the bus value. When the second phase completes, it raises a one-cycle transmit point that marks the start of the next bit.

The block locks to the bus on recessive-to-dominant transitions. While `bus_idle_i` is high, such a transition restarts bit timing outright (hard synchronization). While a frame is in progress, a transition instead nudges the current bit. A transition that falls inside the first phase stretches that phase. A transition that falls inside the second phase shortens the bit. Both corrections are bounded by the jump width. After any synchronization, further transitions are ignored until the next sample strobe. Frame decoding is left to the logic that consumes the strobe and the sampled bit.

Top module: `can_bit_sync`

## Requirements
- R1: With no dominant-going edges, consecutive sample strobes are (tseg1_i+tseg2_i+3)*(brp_i+1) clock cycles apart. The transmit point is (tseg2_i+1)*(brp_i+1) cycles after each sample strobe and occurs while the sync phase is active. The sample strobe occurs while the second phase is active.
- R2: Exactly one of the three phase states (sync, first, second) is active in every cycle, so the sample strobe and the transmit point are never high in the same cycle.
- R3: At most one of the three phase-entry pulses (into sync, into first, into second) is high in any cycle.
- R4: Let the clock edge at which rx_i is first seen low after being high, with bus_idle_i high, be edge 0. Bit timing then restarts, and the sample strobe is high in the cycle that follows edge (tseg1_i+2)*(brp_i+1).
- R5: A 1-to-0 transition seen with bus_idle_i low while the first phase is in its quantum m (counted from 0) lengthens that phase by min(sjw_i+1, m+1) quanta. The sample strobe is delayed by that many quanta.
- R6: A 1-to-0 transition seen with bus_idle_i low while the second phase is in its quantum m (counted from 0) is handled by the quanta left, tseg2_i+1-m. If that count is at most sjw_i+1, a new bit starts at once, timed as in R4. Otherwise the second phase is cut by sjw_i+1 quanta.
- R7: A 0-to-1 transition on rx_i never changes bit timing, whether the bus is idle or not.
- R8: After a synchronization, further 1-to-0 transitions with bus_idle_i low are ignored until the next sample strobe.
- R9: The sample strobe lasts one cycle. From the cycle of the strobe on, bit_o holds the value rx_i had at the clock edge that raised the strobe.
- R10: During reset, sample_o and tx_point_o are low and bit_o is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Bus receive line, 0 = dominant |
| bus_idle_i | input | 1 | High while no frame is in progress |
| brp_i | input | BRP_W | Quantum length minus one, in clock cycles |
| tseg1_i | input | TSEG1_W | First phase length minus one, in quanta |
| tseg2_i | input | TSEG2_W | Second phase length minus one, in quanta |
| sjw_i | input | SJW_W | Jump width minus one, in quanta |
| sample_o | output | 1 | One-cycle sample strobe |
| bit_o | output | 1 | Bus value taken at the last sample strobe |
| tx_point_o | output | 1 | One-cycle pulse at the start of each bit |

## Verification
The bench builds the block with its default widths: a 6-bit prescaler, a 4-bit first phase, a 3-bit second phase and a 2-bit jump width. With these widths the longest phases (16 and 8 quanta) can be reached, and so can the shortest bit of 3 clocks. The timing table sweeps from a one-clock quantum with one-quantum phases up to three-clock quanta with both phases at their maximum. The edge tests use a two-clock quantum and jump widths of 1 and 2 quanta. With those values, both the clamped and the unclamped extension, and both the immediate restart and the bounded cut of the second phase, land on distinct, countable clock edges.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [2:0] {
    SEG_SYNC = 3'b001,
    SEG_PH1  = 3'b010,
    SEG_PH2  = 3'b100
  } seg_e;
endpackage

// File: rtl/can_bt_rst_sync.sv
module can_bt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= 2'b00;
    else        shift_q <= {shift_q[0], 1'b1};
  end

  assign rst_sync_n = shift_q[1];
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp_i,
  input  logic             restart_i,
  output logic             tq_o
);
  logic [BRP_W-1:0] cnt_q, cnt_d;

  // last clock of the current quantum
  assign tq_o = (cnt_q >= brp_i);

  always_comb begin
    if (restart_i || tq_o) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic fall_o
);
  logic rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b1;
    else        rx_q <= rx_i;
  end

  // recessive-to-dominant only
  assign fall_o = rx_q & ~rx_i;
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int TSEG1_W = 4,
  parameter int TSEG2_W = 3,
  parameter int SJW_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tq_i,
  input  logic               fall_i,
  input  logic               rx_i,
  input  logic               bus_idle_i,
  input  logic [TSEG1_W-1:0] tseg1_i,
  input  logic [TSEG2_W-1:0] tseg2_i,
  input  logic [SJW_W-1:0]   sjw_i,
  output logic [2:0]         seg_state_o,
  output logic               go_sync_o,
  output logic               go_seg1_o,
  output logic               go_seg2_o,
  output logic               restart_o,
  output logic               sample_o,
  output logic               bit_o,
  output logic               tx_point_o
);
  localparam int QC_W = TSEG1_W + 1;
  localparam int CW   = QC_W + 1;

  seg_e            state_q, state_d;
  logic [QC_W-1:0] qc_q, qc_d;
  logic [CW-1:0]   ext_q, ext_d;
  logic [CW-1:0]   cut_q, cut_d;
  logic            done_q, done_d;
  logic            samp_q, samp_d;
  logic            bit_q, bit_d;
  logic            tx_q, tx_d;

  logic [CW-1:0] t1_w, t2_w, sj_w, qc_w, rem, ext_new, ext_eff, cut_eff;
  logic hard, resync_ok, late, early, early_jump, early_cut;
  logic sync_end, seg1_end, seg2_end, go_sync, go_seg1, go_seg2;

  // ---------------- event decode ----------------
  always_comb begin
    t1_w = {{(CW-TSEG1_W){1'b0}}, tseg1_i};
    t2_w = {{(CW-TSEG2_W){1'b0}}, tseg2_i};
    sj_w = {{(CW-SJW_W){1'b0}}, sjw_i} + 1'b1;
    qc_w = {1'b0, qc_q};

    hard      = fall_i & bus_idle_i;
    resync_ok = fall_i & ~bus_idle_i & ~done_q;
    late      = resync_ok & (state_q == SEG_PH1);
    early     = resync_ok & (state_q == SEG_PH2);

    // late edge: phase error is quanta already spent in phase 1 plus one
    ext_new = ((qc_w + 1'b1) < sj_w) ? (qc_w + 1'b1) : sj_w;
    ext_eff = late ? ext_new : ext_q;

    // early edge: quanta of phase 2 still to run, current one included
    rem        = t2_w + 1'b1 - qc_w;
    early_jump = early & (rem <= sj_w);
    early_cut  = early & ~early_jump;
    cut_eff    = early_cut ? sj_w : cut_q;

    sync_end = (state_q == SEG_SYNC) & tq_i;
    seg1_end = (state_q == SEG_PH1) & tq_i & (qc_w >= (t1_w + ext_eff));
    seg2_end = (state_q == SEG_PH2) & tq_i & ((qc_w + cut_eff) >= t2_w);

    go_sync = hard | early_jump | seg2_end;
    go_seg1 = sync_end & ~go_sync;
    go_seg2 = seg1_end & ~go_sync;
  end

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    if (go_sync)      state_d = SEG_SYNC;
    else if (go_seg1) state_d = SEG_PH1;
    else if (go_seg2) state_d = SEG_PH2;

    if (go_sync || go_seg1 || go_seg2) qc_d = '0;
    else if (tq_i)                     qc_d = qc_q + 1'b1;
    else                               qc_d = qc_q;

    ext_d = go_seg1 ? '0 : ext_eff;
    cut_d = go_seg2 ? '0 : cut_eff;

    if (hard || late || early) done_d = 1'b1;
    else if (go_seg2)          done_d = 1'b0;
    else                       done_d = done_q;

    samp_d = go_seg2;
    bit_d  = go_seg2 ? rx_i : bit_q;
    tx_d   = seg2_end | early_jump;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEG_SYNC;
      qc_q    <= '0;
      ext_q   <= '0;
      cut_q   <= '0;
      done_q  <= 1'b0;
      samp_q  <= 1'b0;
      bit_q   <= 1'b1;
      tx_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      qc_q    <= qc_d;
      ext_q   <= ext_d;
      cut_q   <= cut_d;
      done_q  <= done_d;
      samp_q  <= samp_d;
      bit_q   <= bit_d;
      tx_q    <= tx_d;
    end
  end

  assign seg_state_o = state_q;
  assign go_sync_o   = go_sync;
  assign go_seg1_o   = go_seg1;
  assign go_seg2_o   = go_seg2;
  assign restart_o   = hard | early_jump;
  assign sample_o    = samp_q;
  assign bit_o       = bit_q;
  assign tx_point_o  = tx_q;
endmodule

// File: rtl/can_bit_sync.sv
module can_bit_sync #(
  parameter int BRP_W   = 6,
  parameter int TSEG1_W = 4,
  parameter int TSEG2_W = 3,
  parameter int SJW_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_i,
  input  logic               bus_idle_i,
  input  logic [BRP_W-1:0]   brp_i,
  input  logic [TSEG1_W-1:0] tseg1_i,
  input  logic [TSEG2_W-1:0] tseg2_i,
  input  logic [SJW_W-1:0]   sjw_i,
  output logic               sample_o,
  output logic               bit_o,
  output logic               tx_point_o
);
  logic       rst_core_n;
  logic       tq, fall, restart;
  logic [2:0] seg_state;
  logic       go_sync, go_seg1, go_seg2;

  can_bt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  can_bt_prescaler #(.BRP_W(BRP_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .brp_i     (brp_i),
    .restart_i (restart),
    .tq_o      (tq)
  );

  can_bt_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .rx_i   (rx_i),
    .fall_o (fall)
  );

  can_bt_seq #(
    .TSEG1_W (TSEG1_W),
    .TSEG2_W (TSEG2_W),
    .SJW_W   (SJW_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .tq_i        (tq),
    .fall_i      (fall),
    .rx_i        (rx_i),
    .bus_idle_i  (bus_idle_i),
    .tseg1_i     (tseg1_i),
    .tseg2_i     (tseg2_i),
    .sjw_i       (sjw_i),
    .seg_state_o (seg_state),
    .go_sync_o   (go_sync),
    .go_seg1_o   (go_seg1),
    .go_seg2_o   (go_seg2),
    .restart_o   (restart),
    .sample_o    (sample_o),
    .bit_o       (bit_o),
    .tx_point_o  (tx_point_o)
  );
endmodule

// File: rtl/can_bit_sync_chk.sv
module can_bit_sync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_i,
  input logic       bus_idle_i,
  input logic       sample_o,
  input logic       bit_o,
  input logic       tx_point_o,
  input logic [2:0] seg_state,
  input logic       go_sync,
  input logic       go_seg1,
  input logic       go_seg2
);
  AST_SEG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seg_state) == 1); // R2

  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_o && tx_point_o)); // R2

  AST_GO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_sync, go_seg1, go_seg2})); // R3

  AST_SAMPLE_IN_PH2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> seg_state == 3'b100); // R1

  AST_TX_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    tx_point_o |-> seg_state == 3'b001); // R1

  AST_HARD_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle_i && !rx_i && $past(rx_i)) |=> seg_state == 3'b001); // R4

  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> !sample_o); // R9

  AST_SAMPLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> bit_o == $past(rx_i)); // R9
endmodule

bind can_bit_sync can_bit_sync_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .rx_i       (rx_i),
  .bus_idle_i (bus_idle_i),
  .sample_o   (sample_o),
  .bit_o      (bit_o),
  .tx_point_o (tx_point_o),
  .seg_state  (seg_state),
  .go_sync    (go_sync),
  .go_seg1    (go_seg1),
  .go_seg2    (go_seg2)
);

// File: tb/can_bit_sync_bench.sv
module can_bit_sync_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       idle = 1'b1;
  logic [5:0] brp = 6'd1;
  logic [3:0] t1 = 4'd3;
  logic [2:0] t2 = 3'd2;
  logic [1:0] sjw = 2'd0;
  logic       sample, bitv, txp;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  int overlap = 0;
  bit finished = 1'b0;

  // rows: brp, tseg1, tseg2, edge-to-sample clocks, sample-to-tx clocks, bit clocks
  localparam int NROW = 5;
  localparam int VEC [NROW][6] = '{
    '{1,  3, 2, 10,  6, 16},
    '{0,  2, 1,  4,  2,  6},
    '{3,  5, 3, 28, 16, 44},
    '{2, 15, 7, 51, 24, 75},
    '{0,  0, 0,  2,  1,  3}
  };

  can_bit_sync u_can_bit_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_i       (rx),
    .bus_idle_i (idle),
    .brp_i      (brp),
    .tseg1_i    (t1),
    .tseg2_i    (t2),
    .sjw_i      (sjw),
    .sample_o   (sample),
    .bit_o      (bitv),
    .tx_point_o (txp)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && sample && txp) overlap <= overlap + 1;

  task automatic summary();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == 150000 && !finished) begin
      n_run  = n_run + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run = n_run + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_sample(output int at);
    int g = 0;
    @(negedge clk);
    while (!sample && g < 3000) begin @(negedge clk); g++; end
    at = cyc;
  endtask

  task automatic wait_tx(output int at);
    int g = 0;
    @(negedge clk);
    while (!txp && g < 3000) begin @(negedge clk); g++; end
    at = cyc;
  endtask

  task automatic drive_at(input int d, input logic v);
    while (cyc < d) @(negedge clk);
    rx = v;
  endtask

  // dominant edge on an idle bus; returns edge cycle and first sample cycle
  task automatic hard_sync(input int off, output int c0, output int s);
    rx = 1'b1; idle = 1'b1;
    repeat (2) @(negedge clk);
    c0 = cyc; rx = 1'b0;
    wait_sample(s);
    chk(s == c0 + 1 + off, "R4 hard sync sample", s, c0 + 1 + off);
    idle = 1'b0;
  endtask

  // directed config: quantum 2 clocks, phase1 4 quanta, phase2 3 quanta, bit 16 clocks
  task automatic late_case(input logic [1:0] jw, input int m, input int ext, input string tag);
    int c0, s;
    brp = 6'd1; t1 = 4'd3; t2 = 3'd2; sjw = jw;
    hard_sync(10, c0, s);
    drive_at(c0 + 12, 1'b1);
    drive_at(c0 + 19 + 2*m, 1'b0);
    wait_sample(s);
    chk(s == c0 + 27 + 2*ext, tag, s, c0 + 27 + 2*ext);
  endtask

  task automatic early_case(input logic [1:0] jw, input int m, input int exp_off, input string tag);
    int c0, s;
    brp = 6'd1; t1 = 4'd3; t2 = 3'd2; sjw = jw;
    hard_sync(10, c0, s);
    drive_at(c0 + 12, 1'b1);
    wait_sample(s);
    chk(s == c0 + 27, "R1 nominal bit before early edge", s, c0 + 27);
    chk(bitv == 1'b1, "R9 sampled recessive", int'(bitv), 1);
    drive_at(c0 + 27 + 2*m, 1'b0);
    wait_sample(s);
    chk(s == c0 + exp_off, tag, s, c0 + exp_off);
  endtask

  initial begin
    int c0, s, s2, t;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(sample == 1'b0, "R10 sample low in reset", int'(sample), 0);
    chk(txp == 1'b0, "R10 tx point low in reset", int'(txp), 0);
    chk(bitv == 1'b1, "R10 bit recessive in reset", int'(bitv), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // timing table: R4 start, R1 tx point and bit length
    for (int i = 0; i < NROW; i++) begin
      brp = VEC[i][0][5:0]; t1 = VEC[i][1][3:0]; t2 = VEC[i][2][2:0]; sjw = 2'd0;
      hard_sync(VEC[i][3], c0, s);
      chk(bitv == 1'b0, "R9 sampled dominant", int'(bitv), 0);
      wait_tx(t);
      chk(t == s + VEC[i][4], "R1 tx point offset", t, s + VEC[i][4]);
      wait_sample(s2);
      chk(s2 == s + VEC[i][5], "R1 bit length", s2, s + VEC[i][5]);
    end

    // R5 late edges
    late_case(2'd1, 0, 1, "R5 late m0 sjw1");
    late_case(2'd0, 3, 1, "R5 late m3 clamped by sjw0");
    late_case(2'd1, 3, 2, "R5 late m3 sjw1");

    // R6 early edges
    early_case(2'd0, 2, 42, "R6 early restart sjw0 m2");
    early_case(2'd0, 0, 41, "R6 early cut sjw0 m0");
    early_case(2'd1, 1, 40, "R6 early restart sjw1 m1");

    // R8 second dominant edge in the same bit is ignored
    brp = 6'd1; t1 = 4'd3; t2 = 3'd2; sjw = 2'd1;
    hard_sync(10, c0, s);
    drive_at(c0 + 12, 1'b1);
    drive_at(c0 + 19, 1'b0);
    drive_at(c0 + 21, 1'b1);
    drive_at(c0 + 23, 1'b0);
    wait_sample(s);
    chk(s == c0 + 29, "R8 only first resync applied", s, c0 + 29);

    // R7 rising edge on an idle bus leaves timing alone
    hard_sync(10, c0, s);
    idle = 1'b1;
    drive_at(c0 + 20, 1'b1);
    wait_sample(s);
    chk(s == c0 + 27, "R7 rising edge ignored", s, c0 + 27);
    chk(bitv == 1'b1, "R7 value after rising edge", int'(bitv), 1);

    chk(overlap == 0, "R2 R3 strobe and tx point apart", overlap, 0);
    summary();
  end
endmodule